// File: doc/BRIEF.md
# Release-Consistency Access Ordering Unit

This unit sits between an in-order stream of labelled memory requests and the memory side. Each request carries a label: plain data, acquire (lock-like) or release (unlock-like). The unit decides when each request may go out on the issue port, so that the memory side sees release-consistent ordering. It tracks outstanding operations through completion tags returned on the completion port.

An acquire goes out at once, but while it is outstanding no later request is accepted. A release is parked in a small in-order queue and goes out only once every operation issued before it has completed. Requests that arrive after a release are not held behind it. Outstanding operations are counted per epoch, where an epoch is the span between two consecutive releases. A queued release therefore waits only for its own epoch's counter to drain. Cache protocol, lock semantics and data values are outside this unit.

Top module: `rc_order_unit`

## Requirements
- R1: After reset nothing is issued (`iss_valid_o` low), no acquire is outstanding, the release queue is empty, all epoch counters are zero and the open epoch is slot 0. A data request is then accepted at once when `iss_ready_i` is high.
- R2: With no acquire outstanding and no release ready, a data request (`req_kind_i` 2'b00 or 2'b11) passes through in the same cycle. `iss_valid_o` follows `req_valid_i`, address, write flag and kind are copied, and `req_ready_o` follows `iss_ready_i`.
- R3: An acquire (`req_kind_i` 2'b01) issues at once. From the cycle after its acceptance until the cycle after a completion carrying the acquire tag, `req_ready_o` is low and no non-release operation is issued.
- R4: A release (`req_kind_i` 2'b10) is never passed through in its arrival cycle. It is queued and issued, with its own address and write flag, only in a cycle after every earlier-issued operation has completed.
- R5: A data request that arrives after a queued release issues without waiting for that release.
- R6: Queued releases issue in arrival order. A release waits for the completion of the release issued before it.
- R7: With REL_DEPTH releases queued, a further release is refused (`req_ready_o` low), while data requests are still accepted.
- R8: A ready queued release takes the issue port ahead of a waiting data request, which sees `req_ready_o` low in that cycle.
- R9: Once 2^CNT_W-1 operations of the current epoch are outstanding, further data requests are held until one completes.
- R10: Tags are {flag, slot}. An acquire carries flag 1 with slot 0. A data op carries flag 0 with the open epoch slot, which starts at 0 and advances by one (mod REL_DEPTH+1) on each accepted release. A release issued from slot k carries slot (k+1) mod (REL_DEPTH+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_kind_i | input | 2 | 00 data, 01 acquire, 10 release, 11 data |
| req_addr_i | input | ADDR_W | Request address |
| req_wr_i | input | 1 | Request is a write |
| iss_valid_o | output | 1 | Operation offered to memory |
| iss_ready_i | input | 1 | Memory takes the operation |
| iss_kind_o | output | 2 | Kind of the issued operation |
| iss_addr_o | output | ADDR_W | Issued address |
| iss_wr_o | output | 1 | Issued write flag |
| iss_tag_o | output | $clog2(REL_DEPTH+1)+1 | Completion tag to be returned |
| cmp_valid_i | input | 1 | Completion present |
| cmp_tag_i | input | $clog2(REL_DEPTH+1)+1 | Tag of the completed operation |

## Verification
On every cycle the assertions check the following. While an acquire is outstanding, no request is accepted and no non-release operation is issued. Tag format matches the kind of each issued operation. A full release queue refuses further releases. A release never appears on the issue port without having been queued first. Issued data or acquire operations always mirror an accepted request. Whether a release really waited for its own epoch, the in-order release issue, the bypass of later data, port priority and the per-epoch limit depend on multi-step histories. Those are shown by the directed scenarios, which track expected tags and completion timing.

// File: rtl/rc_order_pkg.sv
package rc_order_pkg;
  typedef enum logic [1:0] {
    K_DATA = 2'b00,
    K_ACQ  = 2'b01,
    K_REL  = 2'b10,
    K_RSV  = 2'b11
  } op_kind_e;
endpackage

// File: rtl/rc_epoch_ctr.sv
module rc_epoch_ctr #(
  parameter int CNT_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic zero_o,
  output logic full_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (inc_i && !dec_i) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign full_o = &cnt_q;
endmodule

// File: rtl/rc_rel_queue.sv
module rc_rel_queue #(
  parameter int SLOTS  = 3,
  parameter int SLOT_W = 2,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              push_wr_i,
  input  logic              pop_i,
  output logic              head_valid_o,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic              head_wr_o,
  output logic [SLOT_W-1:0] rd_ptr_o,
  output logic [SLOT_W-1:0] rd_nxt_o,
  output logic [SLOT_W-1:0] wr_ptr_o,
  output logic              full_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] rd_q, wr_q, used_q;
  logic [ADDR_W-1:0] addr_q  [SLOTS];
  logic              wflag_q [SLOTS];

  function automatic logic [SLOT_W-1:0] bump(input logic [SLOT_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      wr_q   <= '0;
      used_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      case ({push_i, pop_i})
        2'b10:   used_q <= used_q + 1'b1;
        2'b01:   used_q <= used_q - 1'b1;
        default: used_q <= used_q;
      endcase
    end
  end

  // payload needs no reset: only read while the slot is pending
  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_q]  <= push_addr_i;
      wflag_q[wr_q] <= push_wr_i;
    end
  end

  assign head_valid_o = (used_q != '0);
  assign head_addr_o  = addr_q[rd_q];
  assign head_wr_o    = wflag_q[rd_q];
  assign rd_ptr_o     = rd_q;
  assign rd_nxt_o     = bump(rd_q);
  assign wr_ptr_o     = wr_q;
  assign full_o       = (used_q == LAST);
endmodule

// File: rtl/rc_issue_arb.sv
module rc_issue_arb
  import rc_order_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SLOT_W = 2
) (
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_wr_i,
  input  logic              acq_busy_i,
  input  logic              rel_go_i,
  input  logic [ADDR_W-1:0] head_addr_i,
  input  logic              head_wr_i,
  input  logic              q_full_i,
  input  logic              open_full_i,
  input  logic [SLOT_W-1:0] rd_nxt_i,
  input  logic [SLOT_W-1:0] wr_ptr_i,
  input  logic              iss_ready_i,
  output logic              req_ready_o,
  output logic              iss_valid_o,
  output logic [1:0]        iss_kind_o,
  output logic [ADDR_W-1:0] iss_addr_o,
  output logic              iss_wr_o,
  output logic [SLOT_W:0]   iss_tag_o,
  output logic              data_fire_o,
  output logic              acq_fire_o,
  output logic              rel_push_o,
  output logic              rel_pop_o
);
  logic is_acq, is_rel, is_dat, pass_ok;

  assign is_acq  = (req_kind_i == K_ACQ);
  assign is_rel  = (req_kind_i == K_REL);
  assign is_dat  = !is_acq && !is_rel;
  // request may use the port directly
  assign pass_ok = !acq_busy_i && !rel_go_i && !is_rel && !(is_dat && open_full_i);

  always_comb begin
    iss_valid_o = 1'b0;
    iss_kind_o  = req_kind_i;
    iss_addr_o  = req_addr_i;
    iss_wr_o    = req_wr_i;
    iss_tag_o   = is_acq ? {1'b1, {SLOT_W{1'b0}}} : {1'b0, wr_ptr_i};
    if (rel_go_i) begin
      iss_valid_o = 1'b1;
      iss_kind_o  = K_REL;
      iss_addr_o  = head_addr_i;
      iss_wr_o    = head_wr_i;
      iss_tag_o   = {1'b0, rd_nxt_i};
    end else if (req_valid_i && pass_ok) begin
      iss_valid_o = 1'b1;
    end
  end

  assign req_ready_o = is_rel ? (!acq_busy_i && !q_full_i) : (pass_ok && iss_ready_i);
  assign rel_push_o  = req_valid_i && is_rel && !acq_busy_i && !q_full_i;
  assign rel_pop_o   = rel_go_i && iss_ready_i;
  assign data_fire_o = req_valid_i && is_dat && pass_ok && iss_ready_i;
  assign acq_fire_o  = req_valid_i && is_acq && pass_ok && iss_ready_i;
endmodule

// File: rtl/rc_order_unit.sv
module rc_order_unit #(
  parameter int ADDR_W    = 16,
  parameter int REL_DEPTH = 2,
  parameter int CNT_W     = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_valid_i,
  output logic                             req_ready_o,
  input  logic [1:0]                       req_kind_i,
  input  logic [ADDR_W-1:0]                req_addr_i,
  input  logic                             req_wr_i,
  output logic                             iss_valid_o,
  input  logic                             iss_ready_i,
  output logic [1:0]                       iss_kind_o,
  output logic [ADDR_W-1:0]                iss_addr_o,
  output logic                             iss_wr_o,
  output logic [$clog2(REL_DEPTH+1):0]     iss_tag_o,
  input  logic                             cmp_valid_i,
  input  logic [$clog2(REL_DEPTH+1):0]     cmp_tag_i
);
  localparam int SLOTS  = REL_DEPTH + 1;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int TAG_W  = SLOT_W + 1;

  logic              acq_busy_q;
  logic              data_fire, acq_fire, rel_push, rel_pop, rel_go;
  logic              head_valid, head_wr, q_full, open_full;
  logic [ADDR_W-1:0] head_addr;
  logic [SLOT_W-1:0] rd_ptr, rd_nxt, wr_ptr;
  logic [SLOTS-1:0]  zero_v, full_v;

  rc_rel_queue #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_relq (
    .clk_i, .rst_ni,
    .push_i(rel_push), .push_addr_i(req_addr_i), .push_wr_i(req_wr_i),
    .pop_i(rel_pop),
    .head_valid_o(head_valid), .head_addr_o(head_addr), .head_wr_o(head_wr),
    .rd_ptr_o(rd_ptr), .rd_nxt_o(rd_nxt), .wr_ptr_o(wr_ptr), .full_o(q_full)
  );

  // one outstanding-op counter per epoch slot
  for (genvar s = 0; s < SLOTS; s++) begin : g_epoch
    logic inc, dec;
    assign inc = (data_fire && wr_ptr == SLOT_W'(s)) || (rel_pop && rd_nxt == SLOT_W'(s));
    assign dec = cmp_valid_i && !cmp_tag_i[TAG_W-1] && (cmp_tag_i[SLOT_W-1:0] == SLOT_W'(s));
    rc_epoch_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i, .rst_ni, .inc_i(inc), .dec_i(dec),
      .zero_o(zero_v[s]), .full_o(full_v[s])
    );
  end

  // head epoch drained and the next epoch can absorb the release itself
  assign rel_go    = head_valid && zero_v[rd_ptr] && !full_v[rd_nxt];
  assign open_full = full_v[wr_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   acq_busy_q <= 1'b0;
    else if (acq_fire)                             acq_busy_q <= 1'b1;
    else if (cmp_valid_i && cmp_tag_i[TAG_W-1])    acq_busy_q <= 1'b0;
  end

  rc_issue_arb #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_arb (
    .req_valid_i, .req_kind_i, .req_addr_i, .req_wr_i,
    .acq_busy_i(acq_busy_q), .rel_go_i(rel_go),
    .head_addr_i(head_addr), .head_wr_i(head_wr),
    .q_full_i(q_full), .open_full_i(open_full),
    .rd_nxt_i(rd_nxt), .wr_ptr_i(wr_ptr), .iss_ready_i,
    .req_ready_o, .iss_valid_o, .iss_kind_o, .iss_addr_o, .iss_wr_o, .iss_tag_o,
    .data_fire_o(data_fire), .acq_fire_o(acq_fire),
    .rel_push_o(rel_push), .rel_pop_o(rel_pop)
  );
endmodule

// File: rtl/rc_order_unit_chk.sv
module rc_order_unit_chk
  import rc_order_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int REL_DEPTH = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         req_valid_i,
  input logic                         req_ready_o,
  input logic [1:0]                   req_kind_i,
  input logic [ADDR_W-1:0]            req_addr_i,
  input logic                         req_wr_i,
  input logic                         iss_valid_o,
  input logic                         iss_ready_i,
  input logic [1:0]                   iss_kind_o,
  input logic [ADDR_W-1:0]            iss_addr_o,
  input logic                         iss_wr_o,
  input logic [$clog2(REL_DEPTH+1):0] iss_tag_o,
  input logic                         cmp_valid_i,
  input logic [$clog2(REL_DEPTH+1):0] cmp_tag_i
);
  localparam int SLOT_W = $clog2(REL_DEPTH + 1);
  localparam int TAG_W  = SLOT_W + 1;

  logic             acq_out_q;
  logic [SLOT_W:0]  pend_q;
  logic             req_fire, iss_fire;

  assign req_fire = req_valid_i && req_ready_o;
  assign iss_fire = iss_valid_o && iss_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acq_out_q <= 1'b0;
      pend_q    <= '0;
    end else begin
      if (iss_fire && iss_kind_o == K_ACQ)               acq_out_q <= 1'b1;
      else if (cmp_valid_i && cmp_tag_i[TAG_W-1])       acq_out_q <= 1'b0;
      case ({req_fire && req_kind_i == K_REL, iss_fire && iss_kind_o == K_REL})
        2'b10:   pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  a_r3_acq_blocks_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_out_q |-> !req_ready_o);
  a_r3_acq_blocks_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_out_q |-> !(iss_valid_o && iss_kind_o != K_REL));
  a_r10_acq_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && iss_kind_o == K_ACQ) |-> (iss_tag_o == {1'b1, {SLOT_W{1'b0}}}));
  a_r10_other_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && iss_kind_o != K_ACQ) |-> !iss_tag_o[TAG_W-1]);
  a_r7_full_refuses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == (SLOT_W+1)'(REL_DEPTH) && req_valid_i && req_kind_i == K_REL) |-> !req_ready_o);
  a_r4_rel_from_queue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && iss_kind_o == K_REL) |-> (pend_q != '0));
  a_r2_pass_mirrors_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_fire && iss_kind_o != K_REL) |->
      (req_fire && iss_addr_o == req_addr_i && iss_wr_o == req_wr_i));
endmodule

bind rc_order_unit rc_order_unit_chk #(.ADDR_W(ADDR_W), .REL_DEPTH(REL_DEPTH)) u_chk (.*);

// File: tb/tb_rc_order_unit.sv
`timescale 1ns/1ps
module tb_rc_order_unit;
  localparam int ADDR_W = 16;
  localparam int TAG_W  = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              req_valid_i, req_ready_o, req_wr_i;
  logic [1:0]        req_kind_i;
  logic [ADDR_W-1:0] req_addr_i;
  logic              iss_valid_o, iss_ready_i, iss_wr_o;
  logic [1:0]        iss_kind_o;
  logic [ADDR_W-1:0] iss_addr_o;
  logic [TAG_W-1:0]  iss_tag_o;
  logic              cmp_valid_i;
  logic [TAG_W-1:0]  cmp_tag_i;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  rc_order_unit #(.ADDR_W(ADDR_W), .REL_DEPTH(2), .CNT_W(3)) dut (.*);

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic present(input logic [1:0] k, input logic [15:0] a, input logic w);
    req_valid_i = 1'b1; req_kind_i = k; req_addr_i = a; req_wr_i = w;
    #1;
  endtask

  task automatic accept();
    @(negedge clk_i);
    req_valid_i = 1'b0;
    #1;
  endtask

  task automatic complete(input logic [2:0] t);
    cmp_valid_i = 1'b1; cmp_tag_i = t;
    @(negedge clk_i);
    cmp_valid_i = 1'b0;
    #1;
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic t_reset();
    chk("R1 iss_valid idle", int'(iss_valid_o), 0);
    req_kind_i = 2'b00; #1;
    chk("R1 data ready after reset", int'(req_ready_o), 1);
  endtask

  task automatic t_data();
    present(2'b00, 16'h1234, 1'b1);
    chk("R2 pass valid", int'(iss_valid_o), 1);
    chk("R2 pass addr", int'(iss_addr_o), 'h1234);
    chk("R10 data tag slot0", int'(iss_tag_o), 0);
    iss_ready_i = 1'b0; #1;
    chk("R2 ready follows memory", int'(req_ready_o), 0);
    iss_ready_i = 1'b1; #1;
    accept();
    complete(3'd0);
    present(2'b11, 16'h00ff, 1'b0);
    chk("R2 kind 11 as data", int'(iss_kind_o), 3);
    chk("R2 wr copied", int'(iss_wr_o), 0);
    accept();
    complete(3'd0);
  endtask

  task automatic t_acquire();
    present(2'b01, 16'h0040, 1'b0);
    chk("R3 acquire issues", int'(iss_valid_o), 1);
    chk("R10 acquire tag", int'(iss_tag_o), 4);
    accept();
    present(2'b00, 16'h0041, 1'b1);
    chk("R3 blocked ready", int'(req_ready_o), 0);
    chk("R3 blocked issue", int'(iss_valid_o), 0);
    complete(3'd4);
    chk("R3 unblocked ready", int'(req_ready_o), 1);
    chk("R3 unblocked tag", int'(iss_tag_o), 0);
    accept();
    complete(3'd0);
  endtask

  task automatic t_release();
    present(2'b00, 16'h0100, 1'b1);
    accept();
    present(2'b10, 16'h0055, 1'b1);
    chk("R4 release queued", int'(req_ready_o), 1);
    chk("R4 not passed through", int'(iss_valid_o), 0);
    accept();
    chk("R4 waits for older", int'(iss_valid_o), 0);
    present(2'b00, 16'h0101, 1'b0);
    chk("R5 bypass issue", int'(iss_valid_o), 1);
    chk("R5 bypass kind", int'(iss_kind_o), 0);
    chk("R10 new epoch tag", int'(iss_tag_o), 1);
    accept();
    chk("R4 still waiting", int'(iss_valid_o), 0);
    complete(3'd0);
    chk("R4 release issues", int'(iss_valid_o), 1);
    chk("R4 release kind", int'(iss_kind_o), 2);
    chk("R4 release addr", int'(iss_addr_o), 'h55);
    chk("R10 release tag", int'(iss_tag_o), 1);
    @(negedge clk_i); #1;
    chk("R4 release gone", int'(iss_valid_o), 0);
    complete(3'd1);
    complete(3'd1);
  endtask

  task automatic t_order();
    present(2'b00, 16'h0200, 1'b1);
    accept();
    present(2'b10, 16'h00a0, 1'b1); accept();
    present(2'b10, 16'h00b0, 1'b1); accept();
    present(2'b10, 16'h00c0, 1'b1);
    chk("R7 full refuses release", int'(req_ready_o), 0);
    present(2'b00, 16'h0201, 1'b1);
    chk("R7 data still accepted", int'(req_ready_o), 1);
    chk("R10 wrapped slot tag", int'(iss_tag_o), 0);
    accept();
    complete(3'd1);
    chk("R6 first release", int'(iss_addr_o), 'ha0);
    chk("R6 first release tag", int'(iss_tag_o), 2);
    @(negedge clk_i); #1;
    chk("R6 second waits", int'(iss_valid_o), 0);
    complete(3'd2);
    present(2'b00, 16'h0202, 1'b0);
    chk("R8 release wins port", int'(iss_kind_o), 2);
    chk("R6 second release", int'(iss_addr_o), 'hb0);
    chk("R8 data stalled", int'(req_ready_o), 0);
    @(negedge clk_i); #1;
    chk("R8 data after release", int'(req_ready_o), 1);
    chk("R8 data tag", int'(iss_tag_o), 0);
    accept();
    for (int i = 0; i < 3; i++) complete(3'd0);
  endtask

  task automatic t_limit();
    for (int i = 0; i < 7; i++) begin
      present(2'b00, 16'(i), 1'b1);
      accept();
    end
    present(2'b00, 16'h0300, 1'b1);
    chk("R9 limit holds ready", int'(req_ready_o), 0);
    chk("R9 limit holds issue", int'(iss_valid_o), 0);
    complete(3'd0);
    chk("R9 released after completion", int'(req_ready_o), 1);
    accept();
    for (int i = 0; i < 7; i++) complete(3'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst_ni = 1'b0; req_valid_i = 1'b0; req_kind_i = 2'b00; req_addr_i = '0;
    req_wr_i = 1'b0; iss_ready_i = 1'b1; cmp_valid_i = 1'b0; cmp_tag_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    t_reset();
    t_data();
    t_acquire();
    t_release();
    t_order();
    t_limit();
    finish_up();
  end
endmodule